// File: doc/BRIEF.md
# Serial Slave Interface for a 16-bit Sampled Converter

This block is the digital side of a converter's serial port. A programmable conversion timer stands in for the converter core. While a conversion runs, the block counts down a fixed number of system clock cycles. When the count ends, it captures the `sample_i` word, enters a nap state and holds that word until a host reads it. The host has a chip select (active low), a serial clock and a serial data input. The block drives a serial data output together with an output-enable that models a high-impedance pin.

All three host lines are brought into the system clock domain through synchronizers, and their edges are found there. Reading works with the serial clock idling either high or low. The host reads 16 result bits, most significant bit first. During the same transfer, the first four clock rises carry a configuration word in this order: an enable bit that must be 1, an enable bit that must be 0, a speed bit and a sleep bit. Raising chip select ends a transfer and starts a new conversion, and so does the serial clock falling edge that follows the 16th rise. Pulling chip select low during a conversion returns a status level on the data output.

Top module: `sadc_serial_if`

## Requirements
- R1: After reset, the output-enable is low while chip select is high, fast mode is selected, the sleep setting is clear and the reference-off flag is clear.
- R2: The output-enable is high exactly while the synchronized chip select is low.
- R3: With chip select low and no transfer in progress, the data output is 1 while a conversion runs and 0 once it has completed.
- R4: A conversion lasts CONV_CYCLES system cycles in fast mode (speed bit 0) and CONV_CYCLES*SLOW_FACTOR cycles in slow mode (speed bit 1).
- R5: A chip select falling edge in the nap state starts a transfer. The data output first shows bit 15 of the held result. It moves to the next lower bit on each serial clock fall that follows a rise, so a falling edge that comes before the first rise leaves it unchanged.
- R6: The first four serial clock rises of a transfer capture the input bits, in order, as enable-one, enable-zero, speed and sleep. The speed and sleep settings take the captured values at the next conversion start only when all four bits were captured, enable-one is 1 and enable-zero is 0. Otherwise both settings keep their previous values.
- R7: A chip select rising edge at any point of a transfer, including a transfer with no clock pulses, ends the transfer and starts a conversion.
- R8: After 16 serial clock rises, the next serial clock fall starts a conversion, with or without chip select high.
- R9: When a conversion completes with the sleep setting 1, slow mode off and chip select high, the reference-off flag sets. It clears when chip select goes low. In slow mode the sleep setting has no effect.
- R10: The result read out is the `sample_i` value captured when the conversion completed, whatever `sample_i` does afterwards.
- R11: A chip select rise and the terminating serial clock fall in the same system cycle start exactly one conversion of the normal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select from host, active low, asynchronous |
| sck_i | input | 1 | Serial clock from host, asynchronous |
| sdi_i | input | 1 | Serial configuration input |
| sample_i | input | DATA_W | Converter word captured when a conversion completes |
| sdo_o | output | 1 | Serial data or status; valid while sdo_oe_o is high |
| sdo_oe_o | output | 1 | Output enable; low models a high-impedance pin |
| slow_mode_o | output | 1 | Current speed setting (1 = slow, calibrated) |
| sleep_mode_o | output | 1 | Current sleep setting |
| ref_off_o | output | 1 | Reference powered down |

## Verification
Two functions can fall in the same system cycle: the abort on a chip select rise and the conversion start from the terminating serial clock fall. The bench runs a 16-rise transfer with the clock idling high. It then drops the serial clock and raises chip select in the same system cycle, so both reach the synchronizers together. The collision is judged as correct when the status returns to low after exactly one normal conversion length and the configuration carried in that transfer has been applied.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
   typedef enum logic [1:0] {
      ST_CONV = 2'd0,
      ST_NAP  = 2'd1,
      ST_DOUT = 2'd2
   } sadc_state_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] q_prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sadc_sync: STAGES must be at least 2");
   end

   logic [STAGES:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {(STAGES+1){RST_VAL}};
      else        stg <= {stg[STAGES-1:0], d_i};
   end

   assign q_o      = stg[STAGES-1];
   assign q_prev_o = stg[STAGES];
endmodule

// File: rtl/sadc_conv_timer.sv
module sadc_conv_timer #(
   parameter int CNT_W      = 12,
   parameter int RST_PERIOD = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             done_o
);
   if (RST_PERIOD < 1) begin : g_bad_period
      $error("sadc_conv_timer: RST_PERIOD must be positive");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(RST_PERIOD - 1);
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= period_i - CNT_W'(1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

   assign done_o = busy_q && (cnt_q == '0);

   assert_single_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame #(
   parameter int DATA_W = 16,
   parameter int CFG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              active_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              sdi_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              sdo_bit_o,
   output logic [CFG_W-1:0]  cfg_o,
   output logic              cfg_full_o,
   output logic              last_fall_o
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   if (CFG_W < 4 || CFG_W >= DATA_W) begin : g_bad_cfg
      $error("sadc_frame: CFG_W must be in 4..DATA_W-1");
   end

   logic [DATA_W-1:0] shreg_q;
   logic [CNT_W-1:0]  rise_cnt_q;
   logic [CNT_W-1:0]  adv_cnt_q;
   logic [CFG_W-1:0]  cfg_q;
   logic              advance;

   assign last_fall_o = active_i && fall_i && (rise_cnt_q == CNT_W'(DATA_W));
   assign advance     = active_i && fall_i && (adv_cnt_q < rise_cnt_q) && !last_fall_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q    <= '0;
         rise_cnt_q <= '0;
         adv_cnt_q  <= '0;
         cfg_q      <= '0;
      end else if (load_i) begin
         shreg_q    <= data_i;
         rise_cnt_q <= '0;
         adv_cnt_q  <= '0;
         cfg_q      <= '0;
      end else if (active_i) begin
         if (rise_i && rise_cnt_q < CNT_W'(DATA_W)) rise_cnt_q <= rise_cnt_q + CNT_W'(1);
         if (rise_i && rise_cnt_q < CNT_W'(CFG_W))  cfg_q <= {cfg_q[CFG_W-2:0], sdi_i};
         if (advance) begin
            shreg_q   <= {shreg_q[DATA_W-2:0], 1'b0};
            adv_cnt_q <= adv_cnt_q + CNT_W'(1);
         end
      end
   end

   assign sdo_bit_o  = shreg_q[DATA_W-1];
   assign cfg_o      = cfg_q;
   assign cfg_full_o = rise_cnt_q >= CNT_W'(CFG_W);

   assert_adv_behind_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      adv_cnt_q <= rise_cnt_q);
   assert_term_after_last_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      last_fall_o |-> (adv_cnt_q == CNT_W'(DATA_W - 1)));
endmodule

// File: rtl/sadc_serial_if.sv
module sadc_serial_if
   import sadc_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CFG_W       = 4,
   parameter int CONV_CYCLES = 1000,
   parameter int SLOW_FACTOR = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sck_i,
   input  logic              sdi_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic              slow_mode_o,
   output logic              sleep_mode_o,
   output logic              ref_off_o
);
   localparam int SLOW_CYCLES = CONV_CYCLES * SLOW_FACTOR;
   localparam int PER_W       = $clog2(SLOW_CYCLES + 1);
   localparam int EN1_BIT     = CFG_W - 1;
   localparam int EN2_BIT     = CFG_W - 2;
   localparam int SPD_BIT     = CFG_W - 3;
   localparam int SLP_BIT     = CFG_W - 4;

   if (CONV_CYCLES < 2 || SLOW_FACTOR < 1) begin : g_bad_timing
      $error("sadc_serial_if: CONV_CYCLES >= 2 and SLOW_FACTOR >= 1 required");
   end

   logic [2:0] pins_s, pins_p;
   sadc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_i({cs_n_i, sck_i, sdi_i}),
      .q_o(pins_s), .q_prev_o(pins_p));

   logic cs_s, cs_rise, cs_fall, sck_rise, sck_fall, sdi_s;
   assign cs_s     = pins_s[2];
   assign cs_rise  = pins_s[2] & ~pins_p[2];
   assign cs_fall  = ~pins_s[2] & pins_p[2];
   assign sck_rise = pins_s[1] & ~pins_p[1];
   assign sck_fall = ~pins_s[1] & pins_p[1];
   assign sdi_s    = pins_s[0];

   sadc_state_e       state_q;
   logic [DATA_W-1:0] result_q;
   logic              slow_q, sleep_q, ref_off_q;
   logic              tmr_done, start_conv, load_frame, apply_cfg;
   logic              slow_nxt, sleep_nxt, frame_bit, cfg_full, last_fall;
   logic [CFG_W-1:0]  cfg_word;
   logic [PER_W-1:0]  period;

   sadc_frame #(.DATA_W(DATA_W), .CFG_W(CFG_W)) i_frame (
      .clk(clk), .rst_n(rst_n), .load_i(load_frame), .active_i(state_q == ST_DOUT),
      .rise_i(sck_rise), .fall_i(sck_fall), .sdi_i(sdi_s), .data_i(result_q),
      .sdo_bit_o(frame_bit), .cfg_o(cfg_word), .cfg_full_o(cfg_full),
      .last_fall_o(last_fall));

   assign load_frame = (state_q == ST_NAP) && cs_fall;
   assign start_conv = (state_q == ST_DOUT) && (cs_rise || last_fall);
   assign apply_cfg  = start_conv && cfg_full && cfg_word[EN1_BIT] && !cfg_word[EN2_BIT];
   assign slow_nxt   = apply_cfg ? cfg_word[SPD_BIT] : slow_q;
   assign sleep_nxt  = apply_cfg ? cfg_word[SLP_BIT] : sleep_q;
   assign period     = slow_nxt ? PER_W'(SLOW_CYCLES) : PER_W'(CONV_CYCLES);

   sadc_conv_timer #(.CNT_W(PER_W), .RST_PERIOD(CONV_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .start_i(start_conv), .period_i(period),
      .done_o(tmr_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_CONV;
         result_q  <= '0;
         slow_q    <= 1'b0;
         sleep_q   <= 1'b0;
         ref_off_q <= 1'b0;
      end else begin
         slow_q  <= slow_nxt;
         sleep_q <= sleep_nxt;
         unique case (state_q)
            ST_CONV: if (tmr_done) begin
               state_q  <= ST_NAP;
               result_q <= sample_i;
            end
            ST_NAP:  if (cs_fall)    state_q <= ST_DOUT;
            ST_DOUT: if (start_conv) state_q <= ST_CONV;
            default: state_q <= ST_CONV;
         endcase
         if (!cs_s)
            ref_off_q <= 1'b0;
         else if (state_q == ST_CONV && tmr_done && sleep_q && !slow_q)
            ref_off_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_CONV: sdo_o = 1'b1;
         ST_DOUT: sdo_o = frame_bit;
         default: sdo_o = 1'b0;
      endcase
   end

   assign sdo_oe_o     = ~cs_s;
   assign slow_mode_o  = slow_q;
   assign sleep_mode_o = sleep_q;
   assign ref_off_o    = ref_off_q;

   assert_abort_to_conv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DOUT && cs_rise) |=> (state_q == ST_CONV));
   assert_done_holds_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONV && tmr_done) |=> (state_q == ST_NAP));
   assert_ref_off_in_nap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_off_q |-> (state_q == ST_NAP));
   assert_cfg_only_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !start_conv |=> ($stable(slow_q) && $stable(sleep_q)));
   assert_one_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_conv |=> !start_conv);
endmodule

// File: tb/test_sadc_serial_if.sv
module test_sadc_serial_if;
   localparam int P = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sck = 1'b0;
   logic        sdi = 1'b0;
   logic [15:0] sample = 16'h0000;
   logic        sdo, sdo_oe, slow_mode, sleep_mode, ref_off;
   int          tests = 0;
   int          fails = 0;

   always #5 clk = ~clk;

   sadc_serial_if #(.DATA_W(16), .CFG_W(4), .CONV_CYCLES(P), .SLOW_FACTOR(2),
                    .SYNC_STAGES(2)) i_sadc_serial_if (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
      .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .slow_mode_o(slow_mode),
      .sleep_mode_o(sleep_mode), .ref_off_o(ref_off));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input bit cpol, input logic [3:0] cfg, input int nrise,
                        output logic [15:0] data);
      data = '0;
      cs_n = 1'b0;
      w(6);
      for (int i = 0; i < nrise; i++) begin
         sdi = (i < 4) ? cfg[3-i] : 1'b0;
         if (cpol) begin sck = 1'b0; w(4); end
         if (i < 16) data[15-i] = sdo;
         sck = 1'b1;
         w(4);
         if (!cpol) begin sck = 1'b0; w(4); end
      end
   endtask

   task automatic measure(input bit drop_sck, input int exp_n, input string req);
      int n = 1;
      int first = -1;
      cs_n = 1'b1;
      if (drop_sck) sck = 1'b0;
      @(negedge clk);
      cs_n = 1'b0;
      while (first < 0 && n < exp_n + 20) begin
         @(negedge clk);
         n++;
         if (n == 5) chk({req, " busy status"}, sdo, 1'b1);
         if (n >= 5 && sdo === 1'b0) first = n;
      end
      chk({req, " conversion length"}, first, exp_n);
   endtask

   task automatic t_reset();
      chk("R1 oe", sdo_oe, 1'b0);
      chk("R1 slow", slow_mode, 1'b0);
      chk("R1 sleep", sleep_mode, 1'b0);
      chk("R1 ref_off", ref_off, 1'b0);
   endtask

   task automatic t_status_and_time();
      sample = 16'h1111;
      w(5); cs_n = 1'b0; w(5);
      chk("R2 oe low cs", sdo_oe, 1'b1);
      chk("R3 busy", sdo, 1'b1);
      w(P + 5);
      chk("R3 done", sdo, 1'b0);
      cs_n = 1'b1; w(5);
      chk("R2 oe high cs", sdo_oe, 1'b0);
      cs_n = 1'b0; w(6);
      measure(1'b0, P + 3, "R4 R7 fast no-clock abort");
      cs_n = 1'b1; w(4);
   endtask

   task automatic t_read_idle_low();
      logic [15:0] d;
      sample = 16'hA5C3;
      cs_n = 1'b0; w(6); cs_n = 1'b1; w(P + 8);
      frame(1'b0, 4'b1010, 16, d);
      chk("R5 idle-low data", d, 16'hA5C3);
      w(5);
      chk("R8 16th fall starts", sdo, 1'b1);
      chk("R6 speed applied", slow_mode, 1'b1);
      cs_n = 1'b1; w(2*P + 10);
      cs_n = 1'b0; w(6);
      measure(1'b0, 2*P + 3, "R4 slow");
      cs_n = 1'b1; w(4);
   endtask

   task automatic t_read_idle_high_hold();
      logic [15:0] d;
      sck = 1'b1;
      sample = 16'h3C5A;
      cs_n = 1'b0; w(6); cs_n = 1'b1; w(2*P + 10);
      sample = 16'hFFFF;
      frame(1'b1, 4'b1101, 16, d);
      chk("R10 R5 idle-high held data", d, 16'h3C5A);
      sck = 1'b0; w(5);
      chk("R8 17th pulse starts", sdo, 1'b1);
      chk("R6 bad enable keeps speed", slow_mode, 1'b1);
      chk("R6 bad enable keeps sleep", sleep_mode, 1'b0);
      sck = 1'b1; cs_n = 1'b1; w(2*P + 10);
   endtask

   task automatic t_sleep();
      logic [15:0] d;
      frame(1'b1, 4'b1001, 16, d);
      chk("R10 read", d, 16'hFFFF);
      cs_n = 1'b1; w(5);
      chk("R7 R6 speed after cs end", slow_mode, 1'b0);
      chk("R6 sleep set", sleep_mode, 1'b1);
      w(P + 10);
      chk("R9 ref off", ref_off, 1'b1);
      cs_n = 1'b0; w(4);
      chk("R9 ref on at cs low", ref_off, 1'b0);
   endtask

   task automatic t_sleep_slow();
      logic [15:0] d;
      frame(1'b1, 4'b1011, 16, d);
      cs_n = 1'b1; w(5);
      chk("R6 slow set", slow_mode, 1'b1);
      chk("R6 sleep kept", sleep_mode, 1'b1);
      w(2*P + 10);
      chk("R9 sleep ignored in slow", ref_off, 1'b0);
   endtask

   task automatic t_short_abort();
      logic [15:0] d;
      frame(1'b1, 4'b1000, 2, d);
      cs_n = 1'b1; w(4); cs_n = 1'b0; w(5);
      chk("R7 abort starts conversion", sdo, 1'b1);
      chk("R6 partial word ignored", slow_mode, 1'b1);
      cs_n = 1'b1; w(2*P + 10);
   endtask

   task automatic t_collide();
      logic [15:0] d;
      frame(1'b1, 4'b1000, 16, d);
      measure(1'b1, P + 3, "R11 cs rise with last fall");
      chk("R11 cfg applied once", slow_mode, 1'b0);
      cs_n = 1'b1; w(4);
   endtask

   initial begin
      #(1_500_000);
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      w(3);
      rst_n = 1'b1;
      w(1);
      t_reset();
      t_status_and_time();
      t_read_idle_low();
      t_read_idle_high_hold();
      t_sleep();
      t_sleep_slow();
      t_short_abort();
      t_collide();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule